// File: doc/BRIEF.md
# Hardware Thread State Controller

This block turns a piece of user-defined hardware computation into something that behaves like a software thread. It keeps the thread in one of three run states: idle, running or waiting. A CPU starts and stops the thread through a memory-mapped command register, and it can read the current state at any time from a status register. The CPU can also read and write a thread identifier and an argument word, and it can read a result word that the user logic supplies.

When the user logic needs a lock or a semaphore, it raises a one-cycle request. The request carries an operation code, a target base address and, for semaphores, a request number. The controller parks the thread in the waiting state and issues one bus-master transaction. That transaction carries the address, the operation, the thread identifier as the first parameter and the request number as the second. The controller then holds the request until the bus acknowledges it. A spinning request always returns to running on the response, and the user logic checks the acquired flag and may retry. A blocking request that fails stays waiting, with no bus traffic, until a grant arrives. No context is saved while the thread waits.

Two chip-level controls act on the block. A soft-stop input freezes every internal state machine for as long as it is high. A soft-reset input returns the block to its power-up state without a system reset.

Top module: `hwthread_ctrl`

## Requirements
- R1: After reset the thread is idle, the status register (register index 1) reads 0 and `bm_req` is low.
- R2: Writing command code 2'b01 (run) into bits [1:0] of register index 0 while idle makes the thread running on the next cycle; status bits [1:0] read 2'b01 and `usr_running` is high. The state code is 00 for idle, 01 for running and 10 for waiting.
- R3: A run command while the thread is not idle leaves the state unchanged and sets the sticky error flag, status bit 2. Command code 2'b11 clears that flag.
- R4: A `usr_req` pulse while running moves the thread to waiting. On the next cycle `bm_req` rises, with `bm_addr` equal to the base address, `bm_op` equal to the operation, `bm_p1` equal to the thread id and `bm_p2` equal to the request number for semaphores (op bit 1 set) or 0 for locks. All of these hold steady until `bm_ack`.
- R5: For a spinning operation (op bit 0 clear; 2'b00 spin lock, 2'b10 spin semaphore), the cycle after `bm_ack` the thread is running again, `usr_acquired` equals `bm_status` (1 means acquired), `bm_req` is low and no second request follows.
- R6: For a blocking operation (op bit 0 set; 2'b01 block lock, 2'b11 block semaphore), a successful response returns the thread to running with `usr_acquired` high. A failed response leaves it waiting with `bm_req` low and status bit 4 set, until a `bm_grant` pulse returns it to running with `usr_acquired` high.
- R7: Command code 2'b10 (stop) while running moves the thread to waiting, with `usr_stop_req` high and status bit 5 set. A `usr_stop` pulse then makes it idle. A `usr_stop` pulse while running also makes it idle directly.
- R8: While `soft_stop` is high, the thread state, the bus request and the registers do not change: user requests and CPU writes have no effect.
- R9: A `soft_reset` pulse returns the thread to idle, drops `bm_req`, and clears the thread id, argument, result and error flag.
- R10: Register index 2 holds the thread id and index 3 holds the argument; both are CPU read/write, and the argument appears on `usr_arg`. Register index 4 reads the word the user logic last wrote with `usr_res_we`.
- R11: `usr_done` pulses for exactly one cycle, together with the return to running after a synchronization wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_stop | input | 1 | Freeze all internal state while high |
| soft_reset | input | 1 | Synchronous return to initial state |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 3 | CPU register index |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data for `cpu_addr` |
| usr_req | input | 1 | User synchronization request pulse |
| usr_op | input | 2 | Operation code of the request |
| usr_base | input | ADDR_W | Target base address of the request |
| usr_reqnum | input | RNUM_W | Semaphore request number |
| usr_stop | input | 1 | User thread finished or accepted stop |
| usr_res_we | input | 1 | User result write strobe |
| usr_res_data | input | DATA_W | User result word |
| usr_running | output | 1 | Thread is in the running state |
| usr_stop_req | output | 1 | CPU asked the thread to stop |
| usr_done | output | 1 | One-cycle pulse on return from a synchronization wait |
| usr_acquired | output | 1 | Outcome of the last synchronization request |
| usr_arg | output | DATA_W | Argument register contents |
| bm_req | output | 1 | Bus-master request |
| bm_addr | output | ADDR_W | Request address |
| bm_op | output | 2 | Request operation |
| bm_p1 | output | TID_W | Parameter 1: thread id |
| bm_p2 | output | RNUM_W | Parameter 2: request number |
| bm_ack | input | 1 | Bus acknowledge of the outstanding request |
| bm_status | input | 1 | Response status, 1 means acquired |
| bm_grant | input | 1 | Wake-up grant for a parked blocking request |

## Verification
The assertions assume that the bus answers only an outstanding request and never acknowledges while `soft_stop` is high. They also assume that `bm_grant` arrives only for a blocking request that has been parked after a failed response, and that `usr_req` is raised only while the thread runs. The directed stimulus respects all of this. It drives `bm_ack` only after checking that `bm_req` is high. It pulses `bm_grant` only after a failed blocking response. It exercises freezing with no bus activity pending, and it raises requests during soft stop only to show that they are ignored.

// File: rtl/hwthread_pkg.sv
package hwthread_pkg;

  typedef enum logic [1:0] {
    TS_IDLE = 2'b00,
    TS_RUN  = 2'b01,
    TS_WAIT = 2'b10
  } tstate_e;

  typedef enum logic [1:0] {
    WR_NONE  = 2'b00,
    WR_SPIN  = 2'b01,
    WR_BLOCK = 2'b10,
    WR_STOP  = 2'b11
  } wreason_e;

  // op bit 0: blocking, op bit 1: semaphore (carries request number)
  localparam logic [1:0] OP_SPIN_LOCK  = 2'b00;
  localparam logic [1:0] OP_BLOCK_LOCK = 2'b01;
  localparam logic [1:0] OP_SPIN_SEM   = 2'b10;
  localparam logic [1:0] OP_BLOCK_SEM  = 2'b11;

  localparam logic [1:0] CMD_RUN    = 2'b01;
  localparam logic [1:0] CMD_STOP   = 2'b10;
  localparam logic [1:0] CMD_CLRERR = 2'b11;

  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] REG_CMD    = 3'd0;
  localparam logic [REG_AW-1:0] REG_STATUS = 3'd1;
  localparam logic [REG_AW-1:0] REG_TID    = 3'd2;
  localparam logic [REG_AW-1:0] REG_ARG    = 3'd3;
  localparam logic [REG_AW-1:0] REG_RESULT = 3'd4;

  localparam int unsigned ST_ERR_BIT    = 2;
  localparam int unsigned ST_ACQ_BIT    = 3;
  localparam int unsigned ST_PARK_BIT   = 4;
  localparam int unsigned ST_STOPPD_BIT = 5;

endpackage

// File: rtl/hwthread_regs.sv
module hwthread_regs
  import hwthread_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TID_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 soft_reset,
  input  logic                 cpu_wr,
  input  logic [REG_AW-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    cpu_rdata,
  input  tstate_e              state_i,
  input  logic                 acquired_i,
  input  logic                 parked_i,
  input  logic                 stop_pend_i,
  input  logic                 usr_res_we,
  input  logic [DATA_W-1:0]    usr_res_data,
  output logic                 cmd_run_o,
  output logic                 cmd_stop_o,
  output logic [TID_W-1:0]     tid_o,
  output logic [DATA_W-1:0]    arg_o
);

  logic              wr_cmd;
  logic              cmd_clr;
  logic              tid_we, arg_we, res_we;
  logic              err_q, err_d;
  logic [TID_W-1:0]  tid_q;
  logic [DATA_W-1:0] arg_q, res_q;
  logic [DATA_W-1:0] status_w;

  // command decode: strobes only while not frozen
  always_comb begin
    wr_cmd     = en && cpu_wr && (cpu_addr == REG_CMD);
    cmd_run_o  = wr_cmd && (cpu_wdata[1:0] == CMD_RUN);
    cmd_stop_o = wr_cmd && (cpu_wdata[1:0] == CMD_STOP);
    cmd_clr    = wr_cmd && (cpu_wdata[1:0] == CMD_CLRERR);
    tid_we     = en && cpu_wr && (cpu_addr == REG_TID);
    arg_we     = en && cpu_wr && (cpu_addr == REG_ARG);
    res_we     = en && usr_res_we;
  end

  always_comb begin
    err_d = err_q;
    if (cmd_run_o && (state_i != TS_IDLE)) err_d = 1'b1;
    else if (cmd_clr)                      err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      tid_q <= '0;
      arg_q <= '0;
      res_q <= '0;
    end else if (soft_reset) begin
      err_q <= 1'b0;
      tid_q <= '0;
      arg_q <= '0;
      res_q <= '0;
    end else begin
      if (en)     err_q <= err_d;
      if (tid_we) tid_q <= cpu_wdata[TID_W-1:0];
      if (arg_we) arg_q <= cpu_wdata;
      if (res_we) res_q <= usr_res_data;
    end
  end

  always_comb begin
    status_w                = '0;
    status_w[1:0]           = state_i;
    status_w[ST_ERR_BIT]    = err_q;
    status_w[ST_ACQ_BIT]    = acquired_i;
    status_w[ST_PARK_BIT]   = parked_i;
    status_w[ST_STOPPD_BIT] = stop_pend_i;
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      REG_STATUS: cpu_rdata = status_w;
      REG_TID:    cpu_rdata[TID_W-1:0] = tid_q;
      REG_ARG:    cpu_rdata = arg_q;
      REG_RESULT: cpu_rdata = res_q;
      default:    cpu_rdata = '0;
    endcase
  end

  assign tid_o = tid_q;
  assign arg_o = arg_q;

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_run_o && (state_i != TS_IDLE) && !soft_reset) |=> err_q);

  assert_err_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !soft_reset) |=> !err_q);

endmodule

// File: rtl/hwthread_fsm.sv
module hwthread_fsm
  import hwthread_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       soft_reset,
  input  logic       cmd_run,
  input  logic       cmd_stop,
  input  logic       usr_req,
  input  logic [1:0] usr_op,
  input  logic       usr_stop,
  input  logic       rsp_valid,
  input  logic       rsp_ok,
  input  logic       bm_grant,
  output tstate_e    state_o,
  output logic       parked_o,
  output logic       acquired_o,
  output logic       done_o,
  output logic       stop_pend_o,
  output logic       issue_o
);

  tstate_e  st_q, st_d;
  wreason_e rs_q, rs_d;
  logic     pk_q, pk_d;
  logic     acq_q, acq_d;
  logic     done_q, done_d;
  logic     issue_c;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    rs_d    = rs_q;
    pk_d    = pk_q;
    acq_d   = acq_q;
    done_d  = 1'b0;
    issue_c = 1'b0;
    case (st_q)
      TS_IDLE: begin
        if (cmd_run) begin
          st_d = TS_RUN;
          rs_d = WR_NONE;
        end
      end
      TS_RUN: begin
        if (usr_stop) begin
          st_d = TS_IDLE;
        end else if (usr_req) begin
          st_d    = TS_WAIT;
          rs_d    = usr_op[0] ? WR_BLOCK : WR_SPIN;
          pk_d    = 1'b0;
          issue_c = 1'b1;
        end else if (cmd_stop) begin
          st_d = TS_WAIT;
          rs_d = WR_STOP;
        end
      end
      TS_WAIT: begin
        case (rs_q)
          WR_SPIN: begin
            if (rsp_valid) begin
              st_d   = TS_RUN;
              rs_d   = WR_NONE;
              acq_d  = rsp_ok;
              done_d = 1'b1;
            end
          end
          WR_BLOCK: begin
            if (pk_q) begin
              if (bm_grant) begin
                st_d   = TS_RUN;
                rs_d   = WR_NONE;
                pk_d   = 1'b0;
                acq_d  = 1'b1;
                done_d = 1'b1;
              end
            end else if (rsp_valid) begin
              if (rsp_ok) begin
                st_d   = TS_RUN;
                rs_d   = WR_NONE;
                acq_d  = 1'b1;
                done_d = 1'b1;
              end else begin
                pk_d  = 1'b1;
                acq_d = 1'b0;
              end
            end
          end
          WR_STOP: begin
            if (usr_stop) begin
              st_d = TS_IDLE;
              rs_d = WR_NONE;
            end
          end
          default: begin
            st_d = TS_RUN;
            rs_d = WR_NONE;
          end
        endcase
      end
      default: begin
        st_d = TS_IDLE;
        rs_d = WR_NONE;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_IDLE;
      rs_q   <= WR_NONE;
      pk_q   <= 1'b0;
      acq_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (soft_reset) begin
      st_q   <= TS_IDLE;
      rs_q   <= WR_NONE;
      pk_q   <= 1'b0;
      acq_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (en) begin
      st_q   <= st_d;
      rs_q   <= rs_d;
      pk_q   <= pk_d;
      acq_q  <= acq_d;
      done_q <= done_d;
    end
  end

  assign issue_o     = issue_c && en && !soft_reset;
  assign state_o     = st_q;
  assign parked_o    = pk_q;
  assign acquired_o  = acq_q;
  assign done_o      = done_q;
  assign stop_pend_o = (st_q == TS_WAIT) && (rs_q == WR_STOP);

  assert_idle_to_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_IDLE && cmd_run && !soft_reset) |=> (st_q == TS_RUN));

  assert_spin_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_WAIT && rs_q == WR_SPIN && rsp_valid && en && !soft_reset)
      |=> (st_q == TS_RUN && done_q));

  assert_block_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_WAIT && rs_q == WR_BLOCK && !pk_q && rsp_valid && !rsp_ok && en && !soft_reset)
      |=> (st_q == TS_WAIT && pk_q));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !soft_reset) |=> ($stable(st_q) && $stable(acq_q)));

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> (st_q == TS_IDLE && !acq_q));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && en && !soft_reset) |=> !done_q);

endmodule

// File: rtl/hwthread_busreq.sv
module hwthread_busreq
  import hwthread_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TID_W  = 8,
  parameter int unsigned RNUM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              soft_reset,
  input  logic              issue,
  input  logic [1:0]        usr_op,
  input  logic [ADDR_W-1:0] usr_base,
  input  logic [RNUM_W-1:0] usr_reqnum,
  input  logic [TID_W-1:0]  tid,
  input  logic              bm_ack,
  input  logic              bm_status,
  output logic              bm_req,
  output logic [ADDR_W-1:0] bm_addr,
  output logic [1:0]        bm_op,
  output logic [TID_W-1:0]  bm_p1,
  output logic [RNUM_W-1:0] bm_p2,
  output logic              rsp_valid,
  output logic              rsp_ok
);

  logic              req_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        op_q;
  logic [TID_W-1:0]  p1_q;
  logic [RNUM_W-1:0] p2_q;
  logic [RNUM_W-1:0] p2_d;

  // locks carry no request number
  assign p2_d = usr_op[1] ? usr_reqnum : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      op_q   <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
    end else if (soft_reset) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      op_q   <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
    end else if (en) begin
      if (issue) begin
        req_q  <= 1'b1;
        addr_q <= usr_base;
        op_q   <= usr_op;
        p1_q   <= tid;
        p2_q   <= p2_d;
      end else if (req_q && bm_ack) begin
        req_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = req_q && bm_ack;
  assign rsp_ok    = bm_status;
  assign bm_req    = req_q;
  assign bm_addr   = addr_q;
  assign bm_op     = op_q;
  assign bm_p1     = p1_q;
  assign bm_p2     = p2_q;

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !bm_ack && !soft_reset)
      |=> (req_q && $stable(addr_q) && $stable(op_q) && $stable(p1_q) && $stable(p2_q)));

  assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !req_q);

  assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !req_q);

endmodule

// File: rtl/hwthread_ctrl.sv
module hwthread_ctrl
  import hwthread_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TID_W  = 8,
  parameter int unsigned RNUM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_stop,
  input  logic              soft_reset,
  input  logic              cpu_wr,
  input  logic [2:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              usr_req,
  input  logic [1:0]        usr_op,
  input  logic [ADDR_W-1:0] usr_base,
  input  logic [RNUM_W-1:0] usr_reqnum,
  input  logic              usr_stop,
  input  logic              usr_res_we,
  input  logic [DATA_W-1:0] usr_res_data,
  output logic              usr_running,
  output logic              usr_stop_req,
  output logic              usr_done,
  output logic              usr_acquired,
  output logic [DATA_W-1:0] usr_arg,
  output logic              bm_req,
  output logic [ADDR_W-1:0] bm_addr,
  output logic [1:0]        bm_op,
  output logic [TID_W-1:0]  bm_p1,
  output logic [RNUM_W-1:0] bm_p2,
  input  logic              bm_ack,
  input  logic              bm_status,
  input  logic              bm_grant
);

  logic             en;
  logic             cmd_run, cmd_stop;
  logic [TID_W-1:0] tid;
  tstate_e          state;
  logic             parked, acquired, done, stop_pend, issue;
  logic             rsp_valid, rsp_ok;

  assign en = !soft_stop;

  hwthread_regs #(.DATA_W(DATA_W), .TID_W(TID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(en), .soft_reset(soft_reset),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .state_i(state), .acquired_i(acquired), .parked_i(parked), .stop_pend_i(stop_pend),
    .usr_res_we(usr_res_we), .usr_res_data(usr_res_data),
    .cmd_run_o(cmd_run), .cmd_stop_o(cmd_stop), .tid_o(tid), .arg_o(usr_arg)
  );

  hwthread_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .soft_reset(soft_reset),
    .cmd_run(cmd_run), .cmd_stop(cmd_stop),
    .usr_req(usr_req), .usr_op(usr_op), .usr_stop(usr_stop),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .bm_grant(bm_grant),
    .state_o(state), .parked_o(parked), .acquired_o(acquired), .done_o(done),
    .stop_pend_o(stop_pend), .issue_o(issue)
  );

  hwthread_busreq #(.ADDR_W(ADDR_W), .TID_W(TID_W), .RNUM_W(RNUM_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .en(en), .soft_reset(soft_reset),
    .issue(issue), .usr_op(usr_op), .usr_base(usr_base), .usr_reqnum(usr_reqnum),
    .tid(tid), .bm_ack(bm_ack), .bm_status(bm_status),
    .bm_req(bm_req), .bm_addr(bm_addr), .bm_op(bm_op), .bm_p1(bm_p1), .bm_p2(bm_p2),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
  );

  assign usr_running  = (state == TS_RUN);
  assign usr_stop_req = stop_pend;
  assign usr_done     = done;
  assign usr_acquired = acquired;

  assert_req_only_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req |-> (state == TS_WAIT));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_IDLE) |-> (!bm_req && !usr_done));

endmodule

// File: tb/tb_hwthread_ctrl.sv
`timescale 1ns/1ps
module tb_hwthread_ctrl;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int TID_W  = 8;
  localparam int RNUM_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic soft_stop, soft_reset;
  logic cpu_wr;
  logic [2:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata, cpu_rdata;
  logic usr_req;
  logic [1:0] usr_op;
  logic [ADDR_W-1:0] usr_base;
  logic [RNUM_W-1:0] usr_reqnum;
  logic usr_stop, usr_res_we;
  logic [DATA_W-1:0] usr_res_data;
  logic usr_running, usr_stop_req, usr_done, usr_acquired;
  logic [DATA_W-1:0] usr_arg;
  logic bm_req;
  logic [ADDR_W-1:0] bm_addr;
  logic [1:0] bm_op;
  logic [TID_W-1:0] bm_p1;
  logic [RNUM_W-1:0] bm_p2;
  logic bm_ack, bm_status, bm_grant;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hwthread_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TID_W(TID_W), .RNUM_W(RNUM_W)) dut (
    .clk(clk), .rst_n(rst_n), .soft_stop(soft_stop), .soft_reset(soft_reset),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .usr_req(usr_req), .usr_op(usr_op), .usr_base(usr_base), .usr_reqnum(usr_reqnum),
    .usr_stop(usr_stop), .usr_res_we(usr_res_we), .usr_res_data(usr_res_data),
    .usr_running(usr_running), .usr_stop_req(usr_stop_req), .usr_done(usr_done),
    .usr_acquired(usr_acquired), .usr_arg(usr_arg),
    .bm_req(bm_req), .bm_addr(bm_addr), .bm_op(bm_op), .bm_p1(bm_p1), .bm_p2(bm_p2),
    .bm_ack(bm_ack), .bm_status(bm_status), .bm_grant(bm_grant)
  );

  task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [DATA_W-1:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [DATA_W-1:0] d);
    cpu_addr = a;
    #0.5;
    d = cpu_rdata;
  endtask

  task automatic read_state(output logic [1:0] s);
    logic [DATA_W-1:0] d;
    cpu_read(3'd1, d);
    s = d[1:0];
  endtask

  task automatic pulse_req(input logic [1:0] op, input logic [ADDR_W-1:0] base, input logic [RNUM_W-1:0] num);
    usr_req = 1'b1; usr_op = op; usr_base = base; usr_reqnum = num;
    @(negedge clk);
    usr_req = 1'b0;
  endtask

  task automatic pulse_ack(input logic st);
    bm_ack = 1'b1; bm_status = st;
    @(negedge clk);
    bm_ack = 1'b0; bm_status = 1'b0;
  endtask

  task automatic pulse_usr_stop();
    usr_stop = 1'b1;
    @(negedge clk);
    usr_stop = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    cpu_read(3'd1, d);
    check("R1", "status after reset", d, 0);
    check("R1", "bm_req after reset", bm_req, 0);
    check("R1", "usr_running after reset", usr_running, 0);
  endtask

  task automatic t_run();
    logic [1:0] s;
    cpu_write(3'd0, 32'h1);
    read_state(s);
    check("R2", "state after run cmd", s, 2'b01);
    check("R2", "usr_running", usr_running, 1);
  endtask

  task automatic t_run_err();
    logic [DATA_W-1:0] d;
    cpu_write(3'd0, 32'h1);
    cpu_read(3'd1, d);
    check("R3", "state kept running", d[1:0], 2'b01);
    check("R3", "error flag set", d[2], 1);
    cpu_write(3'd0, 32'h3);
    cpu_read(3'd1, d);
    check("R3", "error flag cleared", d[2], 0);
  endtask

  task automatic t_spin();
    logic [1:0] s;
    cpu_write(3'd2, 32'h5A);
    pulse_req(2'b00, 32'hA000_0010, 8'h33);
    read_state(s);
    check("R4", "state waiting", s, 2'b10);
    check("R4", "bm_req raised", bm_req, 1);
    check("R4", "bm_addr", bm_addr, 32'hA000_0010);
    check("R4", "bm_op", bm_op, 2'b00);
    check("R4", "bm_p1 tid", bm_p1, 8'h5A);
    check("R4", "bm_p2 zero for lock", bm_p2, 0);
    repeat (3) @(negedge clk);
    check("R4", "bm_req held", bm_req, 1);
    check("R4", "bm_addr held", bm_addr, 32'hA000_0010);
    pulse_ack(1'b0);
    read_state(s);
    check("R5", "spin back to run", s, 2'b01);
    check("R5", "acquired = status 0", usr_acquired, 0);
    check("R5", "bm_req dropped", bm_req, 0);
    check("R11", "done pulse", usr_done, 1);
    @(negedge clk);
    check("R11", "done one cycle", usr_done, 0);
    check("R5", "no second request", bm_req, 0);
    // spin semaphore that succeeds
    pulse_req(2'b10, 32'hB000_0000, 8'h07);
    check("R4", "bm_p2 request number", bm_p2, 8'h07);
    pulse_ack(1'b1);
    read_state(s);
    check("R5", "spin sem back to run", s, 2'b01);
    check("R5", "acquired = status 1", usr_acquired, 1);
  endtask

  task automatic t_block();
    logic [DATA_W-1:0] d;
    logic [1:0] s;
    pulse_req(2'b11, 32'hC000_0040, 8'h05);
    check("R4", "block sem p2", bm_p2, 8'h05);
    check("R4", "block sem op", bm_op, 2'b11);
    pulse_ack(1'b0);
    cpu_read(3'd1, d);
    check("R6", "failed block stays waiting", d[1:0], 2'b10);
    check("R6", "parked bit", d[4], 1);
    check("R6", "no bus request while parked", bm_req, 0);
    check("R11", "no done while parked", usr_done, 0);
    repeat (4) @(negedge clk);
    read_state(s);
    check("R6", "still waiting", s, 2'b10);
    bm_grant = 1'b1;
    @(negedge clk);
    bm_grant = 1'b0;
    read_state(s);
    check("R6", "grant returns to run", s, 2'b01);
    check("R6", "grant acquired", usr_acquired, 1);
    check("R11", "done on grant", usr_done, 1);
    // block lock that succeeds at once
    pulse_req(2'b01, 32'hC000_0080, 8'h00);
    pulse_ack(1'b1);
    read_state(s);
    check("R6", "block ok returns to run", s, 2'b01);
    check("R6", "block ok acquired", usr_acquired, 1);
  endtask

  task automatic t_stop();
    logic [DATA_W-1:0] d;
    logic [1:0] s;
    cpu_write(3'd0, 32'h2);
    cpu_read(3'd1, d);
    check("R7", "stop cmd -> waiting", d[1:0], 2'b10);
    check("R7", "stop pending bit", d[5], 1);
    check("R7", "usr_stop_req", usr_stop_req, 1);
    pulse_usr_stop();
    read_state(s);
    check("R7", "user stop -> idle", s, 2'b00);
    check("R7", "stop req cleared", usr_stop_req, 0);
    cpu_write(3'd0, 32'h1);
    pulse_usr_stop();
    read_state(s);
    check("R7", "direct user stop -> idle", s, 2'b00);
  endtask

  task automatic t_soft_stop();
    logic [DATA_W-1:0] d;
    logic [1:0] s;
    cpu_write(3'd0, 32'h1);
    cpu_write(3'd3, 32'h11);
    soft_stop = 1'b1;
    pulse_req(2'b00, 32'hD000_0000, 8'h01);
    cpu_write(3'd0, 32'h2);
    cpu_write(3'd3, 32'h99);
    read_state(s);
    check("R8", "state frozen", s, 2'b01);
    check("R8", "no request while frozen", bm_req, 0);
    cpu_read(3'd3, d);
    check("R8", "arg write ignored", d, 32'h11);
    soft_stop = 1'b0;
    @(negedge clk);
    read_state(s);
    check("R8", "still running after release", s, 2'b01);
    check("R8", "no late request", bm_req, 0);
  endtask

  task automatic t_regs();
    logic [DATA_W-1:0] d;
    cpu_write(3'd2, 32'hC3);
    cpu_write(3'd3, 32'hDEAD_BEEF);
    cpu_read(3'd2, d);
    check("R10", "tid readback", d, 32'hC3);
    cpu_read(3'd3, d);
    check("R10", "arg readback", d, 32'hDEAD_BEEF);
    check("R10", "usr_arg", usr_arg, 32'hDEAD_BEEF);
    usr_res_we = 1'b1; usr_res_data = 32'h1234_5678;
    @(negedge clk);
    usr_res_we = 1'b0;
    cpu_read(3'd4, d);
    check("R10", "result readback", d, 32'h1234_5678);
  endtask

  task automatic t_soft_reset();
    logic [DATA_W-1:0] d;
    cpu_write(3'd0, 32'h1);
    cpu_write(3'd0, 32'h1);
    pulse_req(2'b00, 32'hE000_0000, 8'h00);
    check("R9", "request pending before soft reset", bm_req, 1);
    soft_reset = 1'b1;
    @(negedge clk);
    soft_reset = 1'b0;
    cpu_read(3'd1, d);
    check("R9", "status cleared", d, 0);
    check("R9", "bm_req dropped", bm_req, 0);
    cpu_read(3'd2, d);
    check("R9", "tid cleared", d, 0);
    cpu_read(3'd3, d);
    check("R9", "arg cleared", d, 0);
    cpu_read(3'd4, d);
    check("R9", "result cleared", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; soft_stop = 0; soft_reset = 0;
    cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    usr_req = 0; usr_op = 0; usr_base = 0; usr_reqnum = 0;
    usr_stop = 0; usr_res_we = 0; usr_res_data = 0;
    bm_ack = 0; bm_status = 0; bm_grant = 0;
    @(negedge clk);
    do_reset();
    t_reset();
    t_run();
    t_run_err();
    t_spin();
    t_block();
    t_stop();
    t_soft_stop();
    t_regs();
    t_soft_reset();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule